// File: doc/BRIEF.md
# Windowed Register File

This block is a register file for a processor whose calling convention slides a register window on each procedure call. Instructions name 32 architectural registers with a 5-bit number. Eight of them are global and shared by every window. The other 24 form the current window: eight outputs, eight locals and eight inputs. The block translates each architectural number through a current window pointer into a physical register. The physical array holds the eight globals plus sixteen registers for each of `NWIN` windows. A caller's output registers are the same storage as the callee's input registers, so arguments pass without copying.

A save request moves the pointer to the next window and a restore request moves it back. Each window has a bit in an invalid-window mask, which the surrounding control drives. If a save or restore would enter a window whose bit is set, the block raises overflow or underflow in that cycle and leaves the pointer where it is. Spilling to memory and trap handling are left to the surrounding logic. The file has two combinational read ports and one write port that commits on the clock edge.

Top module: `wrf_top`

## Requirements
- R1: After synchronous reset the window pointer is 0 and every architectural register of every window reads as zero.
- R2: Architectural register 0 always reads as zero, and a write addressed to it changes nothing.
- R3: Registers 1 to 7 are global: a value written to one of them reads back the same from every window, before and after any save or restore.
- R4: A save with no fault moves the pointer from w to (w+1) mod NWIN. The values seen at registers 8 to 15 before the save are then seen at registers 24 to 31.
- R5: A restore with no fault moves the pointer from w to (w-1) mod NWIN. The values seen at registers 24 to 31 before the restore are then seen at registers 8 to 15.
- R6: Locals (registers 16 to 23) belong to a single window. A write to a local is not visible at any register number of the adjacent window after a save or restore, and it reads back again on return.
- R7: If save is high, restore is low and bit (w+1) mod NWIN of the invalid mask is set, overflow_o is high in that same cycle and the pointer does not change.
- R8: If restore is high, save is low and bit (w-1) mod NWIN of the invalid mask is set, underflow_o is high in that same cycle and the pointer does not change.
- R9: A write in the same cycle as a save or restore goes to the physical register selected by the window that was current before the pointer moves.
- R10: A read of the register being written in the same cycle returns the value it held before the write. The new value is seen from the next cycle on.
- R11: When save and restore are both high, the pointer does not change and neither overflow nor underflow is raised.
- R12: Successive saves wrap from window NWIN-1 to window 0, and successive restores wrap from window 0 to window NWIN-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Architectural number for read port A |
| rd_a_data | output | DW | Read port A data, combinational |
| rd_b_addr | input | 5 | Architectural number for read port B |
| rd_b_data | output | DW | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number to write |
| wr_data | input | DW | Write data |
| save_i | input | 1 | Request to move to the next window |
| restore_i | input | 1 | Request to move to the previous window |
| wim_i | input | NWIN | Invalid-window mask, one bit per window |
| cwp_o | output | log2(NWIN) | Current window pointer |
| overflow_o | output | 1 | Save refused because the target window is invalid |
| underflow_o | output | 1 | Restore refused because the target window is invalid |

## Verification
If the window pointer goes wrong, the next read of any windowed register shows it, because reads are combinational and cwp_o is visible directly. A wrong mapping behaves differently: it shows up only when a value written through one window is read through another. The bench therefore compares every read in every cycle with a model, across long runs of saves and restores. Overlap and privacy faults then appear within a few cycles of the window change that exposes them. A wrong fault decision shows on the flag in the same cycle and on the pointer one edge later.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int ARCH_BITS   = 5;
    localparam int GLOBAL_REGS = 8;
    localparam int GROUP_REGS  = 8;
    localparam int WIN_REGS    = 2 * GROUP_REGS;

    // The two top bits of the architectural number select the group.
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e                grp;
        logic [2:0]              idx;
    } arch_reg_t;

    function automatic arch_reg_t split_arch(input logic [ARCH_BITS-1:0] a);
        arch_reg_t r;
        r.grp = reg_grp_e'(a[4:3]);
        r.idx = a[2:0];
        return r;
    endfunction

    function automatic int win_step(input int w, input int nwin, input bit up);
        if (up) return (w == nwin - 1) ? 0 : w + 1;
        return (w == 0) ? nwin - 1 : w - 1;
    endfunction

endpackage

// File: rtl/wrf_map.sv
module wrf_map
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [CW-1:0]        cwp,
    input  logic [ARCH_BITS-1:0] arch,
    output logic [PW-1:0]        phys
);
    arch_reg_t ar;
    int        cur_w;
    int        prev_w;
    int        slot;

    always_comb begin
        ar     = split_arch(arch);
        cur_w  = int'(cwp);
        prev_w = win_step(cur_w, NWIN, 1'b0);
        // Window w owns its outputs and locals; its inputs are the
        // outputs of window w-1, so a save exposes them as inputs.
        unique case (ar.grp)
            GRP_GLOBAL: slot = int'(ar.idx);
            GRP_OUT:    slot = GLOBAL_REGS + WIN_REGS * cur_w + int'(ar.idx);
            GRP_LOCAL:  slot = GLOBAL_REGS + WIN_REGS * cur_w + GROUP_REGS + int'(ar.idx);
            default:    slot = GLOBAL_REGS + WIN_REGS * prev_w + int'(ar.idx);
        endcase
        phys = PW'(slot);
    end

endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] invalid_mask,
    output logic [CW-1:0]   cwp,
    output logic            ovf,
    output logic            unf
);
    logic [CW-1:0] up_w;
    logic [CW-1:0] down_w;
    logic          do_save;
    logic          do_restore;

    always_comb begin
        up_w       = CW'(win_step(int'(cwp), NWIN, 1'b1));
        down_w     = CW'(win_step(int'(cwp), NWIN, 1'b0));
        do_save    = save_req && !restore_req;
        do_restore = restore_req && !save_req;
        ovf        = do_save && invalid_mask[up_w];
        unf        = do_restore && invalid_mask[down_w];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp <= '0;
        end else if (do_save && !ovf) begin
            cwp <= up_w;
        end else if (do_restore && !unf) begin
            cwp <= down_w;
        end
    end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int DW   = 32,
    parameter int NPHY = 136,
    parameter int PW   = 8,
    parameter int NRD  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][PW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] cells [NPHY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHY; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Reads see the array before the edge: no bypass of the write.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cells[raddr[p]];
    end

endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [4:0]                    rd_a_addr,
    output logic [DW-1:0]                 rd_a_data,
    input  logic [4:0]                    rd_b_addr,
    output logic [DW-1:0]                 rd_b_data,
    input  logic                          wr_en,
    input  logic [4:0]                    wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          save_i,
    input  logic                          restore_i,
    input  logic [NWIN-1:0]               wim_i,
    output logic [$clog2(NWIN)-1:0]       cwp_o,
    output logic                          overflow_o,
    output logic                          underflow_o
);
    localparam int CW    = $clog2(NWIN);
    localparam int NPHY  = GLOBAL_REGS + WIN_REGS * NWIN;
    localparam int PW    = $clog2(NPHY);
    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    logic [NPORT-1:0][ARCH_BITS-1:0] port_arch;
    logic [NPORT-1:0][PW-1:0]        port_phys;
    logic [NRD-1:0][PW-1:0]          rd_phys;
    logic [NRD-1:0][DW-1:0]          rd_raw;
    logic                            wr_live;

    assign port_arch = {wr_addr, rd_b_addr, rd_a_addr};

    wrf_window_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .save_req     (save_i),
        .restore_req  (restore_i),
        .invalid_mask (wim_i),
        .cwp          (cwp_o),
        .ovf          (overflow_o),
        .unf          (underflow_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .cwp  (cwp_o),
            .arch (port_arch[p]),
            .phys (port_phys[p])
        );
    end

    assign rd_phys = port_phys[NRD-1:0];
    assign wr_live = wr_en && (wr_addr != '0);

    wrf_storage #(.DW(DW), .NPHY(NPHY), .PW(PW), .NRD(NRD)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_live),
        .waddr (port_phys[NRD]),
        .wdata (wr_data),
        .raddr (rd_phys),
        .rdata (rd_raw)
    );

    assign rd_a_data = (rd_a_addr == '0) ? '0 : rd_raw[0];
    assign rd_b_data = (rd_b_addr == '0) ? '0 : rd_raw[1];

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [4:0]              rd_a_addr,
    input logic [DW-1:0]           rd_a_data,
    input logic [4:0]              rd_b_addr,
    input logic [DW-1:0]           rd_b_data,
    input logic                    save_i,
    input logic                    restore_i,
    input logic [$clog2(NWIN)-1:0] cwp_o,
    input logic                    overflow_o,
    input logic                    underflow_o
);
    localparam int CW = $clog2(NWIN);

    function automatic logic [CW-1:0] ring_up(input logic [CW-1:0] w);
        return (int'(w) == NWIN - 1) ? '0 : CW'(int'(w) + 1);
    endfunction

    function automatic logic [CW-1:0] ring_down(input logic [CW-1:0] w);
        return (w == '0) ? CW'(NWIN - 1) : CW'(int'(w) - 1);
    endfunction

    assert_zero_a_R2: assert property (@(posedge clk) disable iff (rst)
        rd_a_addr == 5'd0 |-> rd_a_data == '0);
    assert_zero_b_R2: assert property (@(posedge clk) disable iff (rst)
        rd_b_addr == 5'd0 |-> rd_b_data == '0);
    assert_save_step_R4: assert property (@(posedge clk) disable iff (rst)
        save_i && !restore_i && !overflow_o |=> cwp_o == ring_up($past(cwp_o)));
    assert_restore_step_R5: assert property (@(posedge clk) disable iff (rst)
        restore_i && !save_i && !underflow_o |=> cwp_o == ring_down($past(cwp_o)));
    assert_no_move_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> $stable(cwp_o));
    assert_no_move_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> $stable(cwp_o));
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({overflow_o, underflow_o}));
    assert_both_no_flag_R11: assert property (@(posedge clk) disable iff (rst)
        save_i && restore_i |-> !overflow_o && !underflow_o);
    assert_both_hold_R11: assert property (@(posedge clk) disable iff (rst)
        save_i && restore_i |=> $stable(cwp_o));

endmodule

bind wrf_top wrf_checker #(.NWIN(NWIN), .DW(DW)) u_chk (.*);

// File: tb/wrf_top_tb_top.sv
module wrf_top_tb_top;
    localparam int NWIN = 8;
    localparam int DW   = 32;
    localparam int CW   = 3;
    localparam int NPHY = 8 + 16 * NWIN;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [4:0]      rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [DW-1:0]   rd_a_data, rd_b_data, wr_data = '0;
    logic            wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0;
    logic [NWIN-1:0] wim_i = '0;
    logic [CW-1:0]   cwp_o;
    logic            overflow_o, underflow_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic [DW-1:0] mdl [NPHY];
    int            mcwp;

    always #4 clk = ~clk;

    wrf_top #(.NWIN(NWIN), .DW(DW)) dut_i (.*);

    function automatic int step(input int w, input bit up);
        if (up) return (w + 1) % NWIN;
        return (w + NWIN - 1) % NWIN;
    endfunction

    // Physical slot from the requirements: globals first, then sixteen
    // per window; inputs of w are outputs of w-1.
    function automatic int slot_of(input int w, input logic [4:0] a);
        int i = int'(a[2:0]);
        case (a[4:3])
            2'd0:    return i;
            2'd1:    return 8 + 16 * w + i;
            2'd2:    return 16 + 16 * w + i;
            default: return 8 + 16 * step(w, 1'b0) + i;
        endcase
    endfunction

    function automatic logic [DW-1:0] mread(input logic [4:0] a);
        if (a == 5'd0) return '0;
        return mdl[slot_of(mcwp, a)];
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic s, input logic r,
                       input logic [NWIN-1:0] wm, input logic we,
                       input logic [4:0] wa, input logic [DW-1:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
        bit ovf_e, unf_e;
        save_i = s; restore_i = r; wim_i = wm;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #1;
        ovf_e = s && !r && wm[step(mcwp, 1'b1)];
        unf_e = r && !s && wm[step(mcwp, 1'b0)];
        chk({tag, " rd_a"}, rd_a_data, mread(ra));
        chk({tag, " rd_b"}, rd_b_data, mread(rb));
        chk({tag, " cwp"}, DW'(cwp_o), DW'(mcwp));
        chk({tag, " ovf"}, DW'(overflow_o), DW'(ovf_e));
        chk({tag, " unf"}, DW'(underflow_o), DW'(unf_e));
        @(posedge clk);
        if (we && wa != 5'd0) mdl[slot_of(mcwp, wa)] = wd;
        if (s && !r && !ovf_e) mcwp = step(mcwp, 1'b1);
        else if (r && !s && !unf_e) mcwp = step(mcwp, 1'b0);
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [4:0] b);
        cyc(tag, 1'b0, 1'b0, '0, 1'b0, 5'd0, '0, a, b);
    endtask

    task automatic wr(input string tag, input logic [4:0] a, input logic [DW-1:0] d);
        cyc(tag, 1'b0, 1'b0, '0, 1'b1, a, d, a, 5'd0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            summary();
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < NPHY; i++) mdl[i] = '0;
        mcwp = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state across all register numbers
        for (int i = 0; i < 16; i++) rd("R1", 5'(2 * i), 5'(2 * i + 1));

        // R2: register 0
        cyc("R2", 1'b0, 1'b0, '0, 1'b1, 5'd0, 32'hdead_beef, 5'd0, 5'd0);
        rd("R2", 5'd0, 5'd0);

        // R3: globals across windows
        for (int i = 1; i < 8; i++) wr("R3", 5'(i), 32'h100 + 32'(i));
        cyc("R3", 1'b1, 1'b0, '0, 1'b0, 5'd0, '0, 5'd1, 5'd7);
        rd("R3", 5'd3, 5'd5);
        cyc("R3", 1'b0, 1'b1, '0, 1'b0, 5'd0, '0, 5'd2, 5'd6);

        // R4 / R6: outputs become inputs, locals stay private
        for (int i = 8; i < 24; i++) wr("R4", 5'(i), 32'h200 + 32'(i));
        cyc("R4", 1'b1, 1'b0, '0, 1'b0, 5'd0, '0, 5'd8, 5'd16);
        for (int i = 0; i < 8; i++) rd("R4", 5'(24 + i), 5'(16 + i));
        for (int i = 8; i < 16; i++) rd("R6", 5'(i), 5'(i + 8));
        wr("R6", 5'd16, 32'h0bad_0001);

        // R5: restore brings inputs back as outputs, old locals return
        wr("R5", 5'd24, 32'h3333_0024);
        cyc("R5", 1'b0, 1'b1, '0, 1'b0, 5'd0, '0, 5'd24, 5'd16);
        rd("R5", 5'd8, 5'd16);
        rd("R6", 5'd17, 5'd9);

        // R7: overflow into a marked window
        cyc("R7", 1'b1, 1'b0, 8'b0000_0010, 1'b0, 5'd0, '0, 5'd8, 5'd9);
        rd("R7", 5'd8, 5'd16);
        // R8: underflow into a marked window
        cyc("R8", 1'b0, 1'b1, 8'b1000_0000, 1'b0, 5'd0, '0, 5'd24, 5'd8);
        rd("R8", 5'd24, 5'd8);

        // R11: both requests together
        cyc("R11", 1'b1, 1'b1, 8'hff, 1'b0, 5'd0, '0, 5'd8, 5'd24);
        rd("R11", 5'd8, 5'd24);

        // R9: write with save uses the old window
        cyc("R9", 1'b1, 1'b0, '0, 1'b1, 5'd10, 32'h9999_0010, 5'd10, 5'd26);
        rd("R9", 5'd26, 5'd10);
        cyc("R9", 1'b0, 1'b1, '0, 1'b1, 5'd12, 32'h9999_0012, 5'd12, 5'd28);
        rd("R9", 5'd12, 5'd28);

        // R10: read during write returns the old value
        cyc("R10", 1'b0, 1'b0, '0, 1'b1, 5'd20, 32'haaaa_0020, 5'd20, 5'd20);
        rd("R10", 5'd20, 5'd20);

        // R12: wrap in both directions
        for (int i = 0; i < NWIN + 2; i++)
            cyc("R12", 1'b1, 1'b0, '0, 1'b1, 5'd9, 32'(i), 5'd25, 5'd9);
        for (int i = 0; i < 2 * NWIN; i++)
            cyc("R12", 1'b0, 1'b1, '0, 1'b0, 5'd0, '0, 5'd9, 5'd25);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [NWIN-1:0] wm;
            int op;
            op = $urandom_range(0, 9);
            wm = ($urandom_range(0, 3) == 0) ? NWIN'(1 << $urandom_range(0, NWIN - 1)) : '0;
            cyc("RAND", op == 0 || op == 2, op == 1 || op == 2, wm,
                $urandom_range(0, 1) == 1, 5'($urandom), $urandom,
                5'($urandom), 5'($urandom));
        end

        summary();
    end

endmodule